// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects up to 64 interrupt sources in two banks of 32 and presents the highest-priority request to a processor on two lines: a normal request line and a fast request line. Every source has its own configuration word that holds a 5-bit priority, a choice between edge and level sensing, and a routing bit that sends it to the fast line. Software masks sources individually and reads a latched pending status. For each line it reads a "winner" register that names the source being served.

The second bank is cascaded: its normal-line request drives one input of the first bank, with the position set by a parameter. Software that finds the cascade input as the first-bank winner reads the second bank's winner and adds 32 to get a global source number. A global number splits into bank = number >> 5 and index = number & 0x1F. A winner stays frozen until software acknowledges it, and a cascaded source needs an acknowledge in both banks. A gate register in the first bank holds both processor lines low until software opens it.

All registers sit behind a single-cycle port. A write takes effect on the clock edge that samples it, and a read returns data combinationally from the address. Byte address bit 8 selects the bank, where 0 is the first bank. Bits 7:2 select a word, and bits 1:0 must be zero. Unaligned accesses are ignored and read as zero.

Top module: `intc_cascade`

## Requirements
- R1: After reset, every mask bit reads 1 (offset 0x04), the gate reads 1 (offset 0x14), the status and both winner registers read 0, and both processor lines are low.
- R2: The configuration word of source i is at byte offset 0x80 + 4*i. Bit 0 routes the source to the fast line, bit 1 selects level sensing (1) or edge sensing (0), and bits 6:2 hold the priority. The word reads back as written.
- R3: The status register (offset 0x00) shows one pending bit per source. For an edge source, a rising input edge sets the bit and it stays set after the input falls. For a level source, the bit equals the input.
- R4: A mask bit of 1 (offset 0x04) keeps that source from winning. Only pending, unmasked sources compete.
- R5: Among competing sources on one line, the lowest priority value wins. On equal priority, the lowest source index wins.
- R6: The winner registers are at 0x08 for the normal line and 0x0C for the fast line. Each one holds the source index in bits 4:0 and a valid flag in bit 7, and reads 0 when nothing is latched. A latched winner does not change until it is acknowledged, even if a better source arrives.
- R7: Writing the control register (offset 0x10) with bit 0 set acknowledges the normal-line winner, and with bit 1 set acknowledges the fast-line winner. An acknowledge clears the winner's edge-pending bit on the same edge. The winner register then reads 0 until the next clock, when a new winner is taken.
- R8: Writing the status register clears each edge-pending bit whose written data bit is 0. Writing 0 clears them all.
- R9: The fast routing bit takes effect only in the first bank. A second-bank source with that bit set still wins on the normal line, and the second bank's fast winner reads 0.
- R10: The second bank's normal-line request is ORed into first-bank input CASCADE_IN (default 0). A second-bank source then shows as first-bank winner CASCADE_IN, and the second bank's own winner reads the source index. Acknowledging it takes an acknowledge in both banks.
- R11: Gate bit 0 = 1 forces both processor lines low. Writing 0 lets them follow the first-bank winners.
- R12: With the gate open, irq_out is high exactly when a first-bank normal winner is latched, and fiq_out is high exactly when a first-bank fast winner is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l1_src | input | 32 | First-bank source inputs |
| l2_src | input | 32 | Second-bank source inputs |
| addr | input | 9 | Byte address: bit 8 selects the bank, bits 7:2 select the word |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe |
| rdata | output | 32 | Read data, combinational from addr |
| irq_out | output | 1 | Normal interrupt request line |
| fiq_out | output | 1 | Fast interrupt request line |

## Verification
Arbitration is tried with random priorities, fast-line routing, masks and active-source sets, all on level sources. Each trial's winner on both lines is compared with a bench model, which separates priority order, index tie-breaking and mask handling. Directed patterns cover the rest. A single pulse on an edge source shows that edge pending is sticky and how acknowledge and status writes clear it. A better source that arrives while a winner is latched shows that the winner is frozen and is taken only in the cycle after the acknowledge. A second-bank source with its fast bit set checks both the fast-bit suppression in the second bank and the two-level cascade with its double acknowledge.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NSRC    = 32;
    localparam int IDX_W   = $clog2(NSRC);
    localparam int PRIO_W  = 5;
    localparam int DATA_W  = 32;
    localparam int WORD_W  = IDX_W + 1;
    localparam int ADDR_W  = WORD_W + 3;

    // word offsets inside one bank (byte offset = 4 * word)
    localparam logic [WORD_W-1:0] WORD_STAT = WORD_W'(0);
    localparam logic [WORD_W-1:0] WORD_MASK = WORD_W'(1);
    localparam logic [WORD_W-1:0] WORD_IRQN = WORD_W'(2);
    localparam logic [WORD_W-1:0] WORD_FIQN = WORD_W'(3);
    localparam logic [WORD_W-1:0] WORD_CTRL = WORD_W'(4);
    localparam logic [WORD_W-1:0] WORD_GATE = WORD_W'(5);

    localparam logic [ADDR_W-1:0] BYTE_L1_CTRL = {1'b0, WORD_CTRL, 2'b00};

    // per-source configuration word, bit 0 = fast route, bit 1 = level, 6:2 = priority
    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              level;
        logic              to_fiq;
    } src_cfg_t;

    localparam int CFG_W = $bits(src_cfg_t);

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } win_t;

    function automatic logic [DATA_W-1:0] win_word(win_t w);
        return w.vld ? DATA_W'({1'b1, 2'b00, w.idx}) : '0;
    endfunction

endpackage

// File: rtl/intc_arb.sv
module intc_arb #(
    parameter int N  = 32,
    parameter int PW = 5,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    output logic            hit,
    output logic [IW-1:0]   idx
);
    logic [PW-1:0] best;

    // strict compare keeps the lowest index among equal priorities
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = '1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!hit || prio[i*PW +: PW] < best)) begin
                hit  = 1'b1;
                best = prio[i*PW +: PW];
                idx  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter int N         = NSRC,
    parameter int DW        = DATA_W,
    parameter int WW        = WORD_W,
    parameter bit TOP_LEVEL = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  src,
    input  logic          wr_en,
    input  logic [WW-1:0] word,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output win_t          irq_win,
    output win_t          fiq_win
);
    localparam int IW = WW - 1;

    src_cfg_t          cfg [N];
    logic [N-1:0]      mask_q, edge_q, src_d, edge_nxt;
    logic [N-1:0]      pend, fast_sel, irq_req, fiq_req;
    logic [N*PRIO_W-1:0] prio_flat;
    logic              irq_hit, fiq_hit;
    logic [IW-1:0]     irq_idx, fiq_idx;

    logic is_cfg, stat_wr, ack_irq, ack_fiq;
    assign is_cfg  = word[WW-1];
    assign stat_wr = wr_en && word == WORD_STAT;
    assign ack_irq = wr_en && word == WORD_CTRL && wdata[0];
    assign ack_fiq = wr_en && word == WORD_CTRL && wdata[1];

    for (genvar g = 0; g < N; g++) begin : g_src
        assign pend[g]     = cfg[g].level ? src[g] : edge_q[g];
        assign fast_sel[g] = TOP_LEVEL ? cfg[g].to_fiq : 1'b0;
        assign prio_flat[g*PRIO_W +: PRIO_W] = cfg[g].prio;
    end

    assign irq_req = pend & ~mask_q & ~fast_sel;
    assign fiq_req = pend & ~mask_q &  fast_sel;

    intc_arb #(.N(N), .PW(PRIO_W), .IW(IW)) u_arb_irq (
        .req(irq_req), .prio(prio_flat), .hit(irq_hit), .idx(irq_idx)
    );
    intc_arb #(.N(N), .PW(PRIO_W), .IW(IW)) u_arb_fiq (
        .req(fiq_req), .prio(prio_flat), .hit(fiq_hit), .idx(fiq_idx)
    );

    // edge pending: status-write clear, acknowledge clear, then new edges win
    always_comb begin
        edge_nxt = edge_q;
        if (stat_wr)
            edge_nxt = edge_nxt & wdata[N-1:0];
        if (ack_irq && irq_win.vld)
            edge_nxt[irq_win.idx] = 1'b0;
        if (ack_fiq && fiq_win.vld)
            edge_nxt[fiq_win.idx] = 1'b0;
        edge_nxt = edge_nxt | (src & ~src_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '1;
            edge_q  <= '0;
            src_d   <= '0;
            irq_win <= '0;
            fiq_win <= '0;
            for (int i = 0; i < N; i++) cfg[i] <= '0;
        end else begin
            src_d  <= src;
            edge_q <= edge_nxt;
            if (wr_en && word == WORD_MASK)
                mask_q <= wdata[N-1:0];
            if (wr_en && is_cfg)
                cfg[word[IW-1:0]] <= wdata[CFG_W-1:0];

            if (ack_irq)
                irq_win <= '0;
            else if (!irq_win.vld && irq_hit)
                irq_win <= '{vld: 1'b1, idx: irq_idx};

            if (ack_fiq)
                fiq_win <= '0;
            else if (!fiq_win.vld && fiq_hit)
                fiq_win <= '{vld: 1'b1, idx: fiq_idx};
        end
    end

    always_comb begin
        rdata = '0;
        if (is_cfg)
            rdata = DW'(cfg[word[IW-1:0]]);
        else begin
            case (word)
                WORD_STAT: rdata = DW'(pend);
                WORD_MASK: rdata = DW'(mask_q);
                WORD_IRQN: rdata = win_word(irq_win);
                WORD_FIQN: rdata = win_word(fiq_win);
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/intc_cascade.sv
module intc_cascade
    import intc_pkg::*;
#(
    parameter int N          = NSRC,
    parameter int DW         = DATA_W,
    parameter int AW         = $clog2(N) + 4,
    parameter int CASCADE_IN = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  l1_src,
    input  logic [N-1:0]  l2_src,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    output logic [DW-1:0] rdata,
    output logic          irq_out,
    output logic          fiq_out
);
    localparam int WW = AW - 3;

    logic          aligned, sel_l2, wr_l1, wr_l2, gate;
    logic [WW-1:0] word;
    logic [N-1:0]  l1_in;
    logic [DW-1:0] l1_rd, l2_rd;
    win_t          l1_irq_win, l1_fiq_win, l2_irq_win, l2_fiq_win;

    assign aligned = addr[1:0] == 2'b00;
    assign word    = addr[WW+1:2];
    assign sel_l2  = addr[AW-1];
    assign wr_l1   = we && aligned && !sel_l2;
    assign wr_l2   = we && aligned &&  sel_l2;

    assign l1_in = l1_src | (N'(l2_irq_win.vld) << CASCADE_IN);

    intc_bank #(.N(N), .DW(DW), .WW(WW), .TOP_LEVEL(1'b1)) u_l1 (
        .clk(clk), .rst(rst), .src(l1_in), .wr_en(wr_l1), .word(word),
        .wdata(wdata), .rdata(l1_rd), .irq_win(l1_irq_win), .fiq_win(l1_fiq_win)
    );

    intc_bank #(.N(N), .DW(DW), .WW(WW), .TOP_LEVEL(1'b0)) u_l2 (
        .clk(clk), .rst(rst), .src(l2_src), .wr_en(wr_l2), .word(word),
        .wdata(wdata), .rdata(l2_rd), .irq_win(l2_irq_win), .fiq_win(l2_fiq_win)
    );

    always_ff @(posedge clk) begin
        if (rst)
            gate <= 1'b1;
        else if (wr_l1 && word == WORD_GATE)
            gate <= wdata[0];
    end

    always_comb begin
        if (!aligned)
            rdata = '0;
        else if (sel_l2)
            rdata = l2_rd;
        else if (word == WORD_GATE)
            rdata = DW'(gate);
        else
            rdata = l1_rd;
    end

    assign irq_out = l1_irq_win.vld && !gate;
    assign fiq_out = l1_fiq_win.vld && !gate;
endmodule

// File: rtl/intc_chk.sv
module intc_chk
    import intc_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic ack_l1_irq,
    input logic gate,
    input logic irq_out,
    input logic fiq_out,
    input win_t l1_irq_win,
    input win_t l2_fiq_win
);
    // R1: outputs come out of reset low
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!irq_out && !fiq_out && !l1_irq_win.vld));

    // R6: an unacknowledged winner keeps its index
    p_win_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (l1_irq_win.vld && !ack_l1_irq) |=> (l1_irq_win.vld && $stable(l1_irq_win.idx)));

    // R7: acknowledge empties the winner for one clock
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        ack_l1_irq |=> !l1_irq_win.vld);

    // R11: closed gate silences both lines
    p_gate_blocks_r11: assert property (@(posedge clk) disable iff (rst)
        gate |-> (!irq_out && !fiq_out));

    // R9: second bank never latches a fast winner
    p_l2_no_fast_r9: assert property (@(posedge clk) disable iff (rst)
        l2_fiq_win == '0);
endmodule

bind intc_cascade intc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ack_l1_irq (we && addr == intc_pkg::BYTE_L1_CTRL && wdata[0]),
    .gate       (gate),
    .irq_out    (irq_out),
    .fiq_out    (fiq_out),
    .l1_irq_win (l1_irq_win),
    .l2_fiq_win (l2_fiq_win)
);

// File: tb/tb_intc_cascade.sv
`timescale 1ns/1ps
module tb_intc_cascade;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] l1_src = '0, l2_src = '0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic        irq_out, fiq_out;

    int total = 0, bad = 0;
    bit done = 0;

    logic [4:0] m_prio [32];
    bit         m_fiq  [32];

    intc_cascade dut (
        .clk(clk), .rst(rst), .l1_src(l1_src), .l2_src(l2_src),
        .addr(addr), .wdata(wdata), .we(we), .rdata(rdata),
        .irq_out(irq_out), .fiq_out(fiq_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg1(input int i, input logic [4:0] p, input bit lvl, input bit f);
        m_prio[i] = p;
        m_fiq[i]  = f;
        wr(9'h080 + 9'(i*4), {25'b0, p, lvl, f});
    endtask

    function automatic logic [31:0] model_win(logic [31:0] act, logic [31:0] msk, bit want_fiq);
        bit hit = 0;
        logic [4:0] best = '1;
        int w = 0;
        for (int i = 0; i < 32; i++) begin
            if (act[i] && !msk[i] && m_fiq[i] == want_fiq && (!hit || m_prio[i] < best)) begin
                hit = 1; best = m_prio[i]; w = i;
            end
        end
        return hit ? (32'h80 | 32'(w)) : 32'h0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, msk, act, e_irq, e_fiq;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(9'h004, d); chk("R1 mask", d, 32'hFFFF_FFFF);
        rd(9'h104, d); chk("R1 l2 mask", d, 32'hFFFF_FFFF);
        rd(9'h014, d); chk("R1 gate", d, 32'h1);
        rd(9'h000, d); chk("R1 status", d, 32'h0);
        rd(9'h008, d); chk("R1 irq winner", d, 32'h0);
        rd(9'h00C, d); chk("R1 fiq winner", d, 32'h0);
        chk("R1 lines", {30'b0, irq_out, fiq_out}, 32'h0);

        // R2 config read-back
        wr(9'h09C, 32'h5F);
        rd(9'h09C, d); chk("R2 cfg readback", d, 32'h5F);

        wr(9'h014, 32'h0);

        // R4 R5 R6 random arbitration
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < 32; i++)
                cfg1(i, 5'($urandom), 1'b1, 1'($urandom));
            msk = $urandom;
            act = $urandom;
            wr(9'h004, msk);
            @(negedge clk); l1_src = act;
            wr(9'h010, 32'h3);
            idle(1);
            e_irq = model_win(act, msk, 1'b0);
            e_fiq = model_win(act, msk, 1'b1);
            rd(9'h008, d); chk("R5 R4 random irq winner", d, e_irq);
            rd(9'h00C, d); chk("R5 R4 random fiq winner", d, e_fiq);
            chk("R12 irq line", {31'b0, irq_out}, {31'b0, e_irq[7]});
            chk("R12 fiq line", {31'b0, fiq_out}, {31'b0, e_fiq[7]});
        end
        l1_src = '0;

        // R5 tie, R6 frozen, R7 recompute next clock
        cfg1(4, 5'd3, 1'b1, 1'b0);
        cfg1(9, 5'd3, 1'b1, 1'b0);
        cfg1(2, 5'd0, 1'b1, 1'b0);
        wr(9'h004, ~32'h0000_0214);
        @(negedge clk); l1_src = 32'h0000_0210;
        wr(9'h010, 32'h3);
        idle(1);
        rd(9'h008, d); chk("R5 tie low index", d, 32'h84);
        @(negedge clk); l1_src = 32'h0000_0214;
        idle(3);
        rd(9'h008, d); chk("R6 frozen winner", d, 32'h84);
        wr(9'h010, 32'h1);
        rd(9'h008, d); chk("R7 empty after ack", d, 32'h0);
        @(negedge clk);
        rd(9'h008, d); chk("R7 new winner next clock", d, 32'h82);

        // R11 gate
        wr(9'h014, 32'h1);
        chk("R11 gate closed", {31'b0, irq_out}, 32'h0);
        rd(9'h014, d); chk("R11 gate readback", d, 32'h1);
        wr(9'h014, 32'h0);
        chk("R12 gate open", {31'b0, irq_out}, 32'h1);

        // R3 level follows input
        cfg1(13, 5'd0, 1'b1, 1'b0);
        @(negedge clk); l1_src = 32'h0000_2000;
        rd(9'h000, d); chk("R3 level high", d, 32'h0000_2000);
        @(negedge clk); l1_src = '0;
        rd(9'h000, d); chk("R3 level low", d, 32'h0);

        // R3 R7 R8 edge source
        cfg1(12, 5'd0, 1'b0, 1'b0);
        wr(9'h004, ~32'h0000_1000);
        wr(9'h010, 32'h3);
        wr(9'h000, 32'h0);
        @(negedge clk); l1_src = 32'h0000_1000;
        @(negedge clk); l1_src = '0;
        idle(3);
        rd(9'h000, d); chk("R3 edge sticky", d, 32'h0000_1000);
        rd(9'h008, d); chk("R3 edge winner", d, 32'h8C);
        wr(9'h010, 32'h1);
        rd(9'h000, d); chk("R7 ack clears edge", d, 32'h0);
        idle(2);
        rd(9'h008, d); chk("R7 no relatch", d, 32'h0);
        @(negedge clk); l1_src = 32'h0000_1000;
        @(negedge clk); l1_src = '0;
        idle(3);
        rd(9'h000, d); chk("R3 second edge", d, 32'h0000_1000);
        wr(9'h000, 32'h0);
        rd(9'h000, d); chk("R8 status clear", d, 32'h0);
        rd(9'h008, d); chk("R8 winner kept", d, 32'h8C);
        wr(9'h010, 32'h3);

        // fast line on first bank
        cfg1(20, 5'd1, 1'b1, 1'b1);
        wr(9'h004, ~32'h0010_0000);
        @(negedge clk); l1_src = 32'h0010_0000;
        wr(9'h010, 32'h3);
        idle(1);
        rd(9'h00C, d); chk("R2 R12 fast winner", d, 32'h94);
        rd(9'h008, d); chk("R2 normal empty", d, 32'h0);
        chk("R12 fiq_out", {30'b0, irq_out, fiq_out}, 32'h1);
        @(negedge clk); l1_src = '0;

        // R9 R10 cascade
        wr(9'h18C, 32'h07);
        wr(9'h104, ~32'h0000_0008);
        cfg1(0, 5'd0, 1'b1, 1'b0);
        wr(9'h004, ~32'h1);
        @(negedge clk); l2_src = 32'h8;
        wr(9'h110, 32'h3);
        wr(9'h010, 32'h3);
        idle(3);
        rd(9'h10C, d); chk("R9 l2 fast empty", d, 32'h0);
        rd(9'h108, d); chk("R9 l2 routed normal", d, 32'h83);
        rd(9'h008, d); chk("R10 cascade input wins", d, 32'h80);
        chk("R10 global number", 32'd32 + (d[7] ? 32'h0 : 32'hFF) + 32'(3), 32'd35);
        chk("R10 irq_out", {31'b0, irq_out}, 32'h1);
        @(negedge clk); l2_src = '0;
        wr(9'h110, 32'h1);
        wr(9'h010, 32'h1);
        idle(2);
        rd(9'h108, d); chk("R10 l2 acked", d, 32'h0);
        rd(9'h008, d); chk("R10 l1 acked", d, 32'h0);
        chk("R10 line low", {31'b0, irq_out}, 32'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule